// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block lets a host fetch bytes from serial NOR flash through a plain memory-style read port, without running a command sequence itself. A host write port loads a mode switch and one setup word per chip select. When the switch is set, each accepted read request starts a flash read on the requested chip select. The sequence shifts out the programmed opcode, the low address bytes of the request and a programmed number of dummy bytes on one line, most significant bit first. It then shifts in data on one, two or four lines and returns it one byte at a time.

The serial clock runs at half the core clock in SPI mode 0. It idles low, data is launched while it is low and data is captured while it is high. The setup word for a chip select packs its opcode, address length, dummy count and data line count. It is sampled when a request is accepted, so it may be rewritten between reads. The request carries the address, the chip select and a byte count. The response is a byte stream with a valid strobe and a flag on the final byte.

Top module: `mmf_rd_top`

## Requirements
- R1: The switch is configuration word index 4, bit 0 (1 = memory-mapped reads enabled, 0 = off). It resets to 0. While it is 0 and no read is running, `req_ready` stays low, no chip select is asserted and a pending request is held. Setting the bit lets the held request be accepted.
- R2: Configuration word indexes 0 to 3 hold the setup word of chip selects 0 to 3. The layout is: opcode in bits [7:0], address bytes minus one in bits [9:8], dummy byte count in bits [11:10], data line mode in bits [13:12]. The opcode goes out first in every sequence.
- R3: After the opcode, the low N bytes of `req_addr` (N = field + 1, from 1 to 4) are sent on `fl_io_o[0]`, most significant bit first, with `fl_io_oe[0]` high.
- R4: After the address, the number of dummy bytes given by the setup word is clocked out with `fl_io_o[0]` low.
- R5: Line mode 0 captures data on `fl_io_i[1]`, one bit per clock, most significant bit first.
- R6: Line mode 1 captures two bits per clock. The higher bit is on `fl_io_i[1]` and the lower bit is on `fl_io_i[0]`, high pair first.
- R7: Line mode 3 captures four bits per clock on `fl_io_i[3:0]`, bit 3 carrying the higher bit, high nibble first.
- R8: The reserved line mode 2 behaves as line mode 0.
- R9: At most one `fl_cs_n` line is low at a time. The line of `req_cs` goes low on the cycle after acceptance and rises on the cycle the final byte is presented. `fl_sclk` is low whenever no chip select is low.
- R10: A request of `req_len` bytes (1 or more) returns exactly that many bytes, each with a one-cycle `rsp_valid` pulse. The bytes are the flash contents from the sent address upwards, and `rsp_last` is high only with the final byte.
- R11: Only one read runs at a time. `req_ready` is low from the cycle after acceptance until one cycle after the chip select is released.
- R12: While a chip select is low, `fl_sclk` toggles every core clock cycle, and `fl_io_o` changes only on cycles where `fl_sclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | CFG_IDX_W (3) | Configuration word index (0 to 3 setup words, 4 switch) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_addr | input | ADDR_W (32) | Flash byte address |
| req_cs | input | CS_W (2) | Chip select of the request |
| req_len | input | LEN_W (8) | Number of bytes to read, at least 1 |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the request |
| fl_sclk | output | 1 | Serial clock |
| fl_cs_n | output | NUM_CS (4) | Active-low chip selects |
| fl_io_o | output | 4 | Serial data out |
| fl_io_oe | output | 4 | Serial data output enables |
| fl_io_i | input | 4 | Serial data in |

## Verification
The assertions assume that a request never asks for zero bytes. They also assume that the flash answers within the mode 0 timing: it changes its data lines only after a falling serial clock, so the value captured while the clock is high is settled. The bench flash model drives its lines 1 ns after each falling edge and serves bytes only once the full opcode, address and dummy phase has arrived. All requests use lengths from 1 to 16, so every sequence ends well inside the run. The switch is cleared only while no read is running, because the assertion on held requests covers only the idle case.

// File: rtl/mmf_pkg.sv
`timescale 1ns/1ps
package mmf_pkg;

    localparam int SETUP_W      = 14;
    localparam int CMD_MAX_BITS = 64;
    localparam int BYTE_W       = 8;

    typedef enum logic [1:0] {
        LN_ONE  = 2'd0,
        LN_TWO  = 2'd1,
        LN_RSVD = 2'd2,
        LN_FOUR = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [1:0] lanes;
        logic [1:0] dummy_n;
        logic [1:0] abyte_m1;
        logic [7:0] opcode;
    } setup_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_DATA = 2'd2,
        SQ_GAP  = 2'd3
    } seq_state_e;

    function automatic setup_t word_to_setup(input logic [SETUP_W-1:0] w);
        return setup_t'(w);
    endfunction

    // Index of the last serial clock within one data byte
    function automatic logic [2:0] last_chunk(input logic [1:0] mode);
        case (mode)
            LN_FOUR: return 3'd1;
            LN_TWO:  return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    // Serial clocks of the single-line phase, minus one
    function automatic logic [6:0] cmd_last_bit(input setup_t s);
        logic [3:0] nbytes;
        nbytes = 4'd2 + {2'b00, s.abyte_m1} + {2'b00, s.dummy_n};
        return {nbytes, 3'b000} - 7'd1;
    endfunction

endpackage

// File: rtl/mmf_cfg_regs.sv
`timescale 1ns/1ps
module mmf_cfg_regs
    import mmf_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int CFG_IDX_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [CFG_IDX_W-1:0]         cfg_idx,
    input  logic [31:0]                  cfg_wdata,
    output logic                         mm_on,
    output setup_t [NUM_CS-1:0]          setup_bank
);

    localparam logic [CFG_IDX_W-1:0] SWITCH_IDX = CFG_IDX_W'(NUM_CS);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata[31:SETUP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_on <= 1'b0;
        end else if (cfg_we && cfg_idx == SWITCH_IDX) begin
            mm_on <= cfg_wdata[0];
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
        always_ff @(posedge clk) begin
            if (rst) begin
                setup_bank[g] <= '0;
            end else if (cfg_we && cfg_idx == CFG_IDX_W'(g)) begin
                setup_bank[g] <= word_to_setup(cfg_wdata[SETUP_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/mmf_shifter.sv
`timescale 1ns/1ps
module mmf_shifter
    import mmf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  setup_t            sel_setup,
    input  logic [ADDR_W-1:0] addr,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic [1:0]        mode,
    input  logic [3:0]        io_in,
    output logic              tx_bit,
    output logic [BYTE_W-1:0] rx_byte
);

    logic [CMD_MAX_BITS-1:0] cmd_sr;
    logic [31:0]             addr32;
    logic [4:0]              align_sh;
    logic [31:0]             addr_al;
    logic [CMD_MAX_BITS-1:0] load_word;

    assign addr32    = 32'(addr);
    assign align_sh  = {2'd3 - sel_setup.abyte_m1, 3'b000};
    assign addr_al   = addr32 << align_sh;
    assign load_word = {sel_setup.opcode, addr_al, 24'd0};

    // Opcode, address and zero dummy bits leave from the top bit
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sr <= '0;
        end else if (load) begin
            cmd_sr <= load_word;
        end else if (shift_en) begin
            cmd_sr <= {cmd_sr[CMD_MAX_BITS-2:0], 1'b0};
        end
    end

    assign tx_bit = cmd_sr[CMD_MAX_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
        end else if (sample_en) begin
            case (mode)
                LN_FOUR: rx_byte <= {rx_byte[3:0], io_in[3:0]};
                LN_TWO:  rx_byte <= {rx_byte[5:0], io_in[1:0]};
                default: rx_byte <= {rx_byte[6:0], io_in[1]};
            endcase
        end
    end

endmodule

// File: rtl/mmf_seq.sv
`timescale 1ns/1ps
module mmf_seq
    import mmf_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mm_on,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [LEN_W-1:0]  req_len,
    input  setup_t            sel_setup,
    output logic              load,
    output logic              shift_en,
    output logic              sample_en,
    output logic [1:0]        mode,
    output logic              tx_en,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              rsp_valid,
    output logic              rsp_last
);

    seq_state_e       state;
    logic             ph;
    logic [6:0]       cnt;
    logic [LEN_W-1:0] bytes_left;
    logic [1:0]       mode_q;

    assign req_ready = mm_on && (state == SQ_IDLE);
    assign load      = req_valid && req_ready;
    assign shift_en  = (state == SQ_CMD) && ph;
    assign sample_en = (state == SQ_DATA) && ph;
    assign mode      = mode_q;
    assign tx_en     = (state == SQ_CMD);
    assign sclk      = ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            ph         <= 1'b0;
            cnt        <= '0;
            bytes_left <= '0;
            mode_q     <= LN_ONE;
            cs_n       <= '1;
            rsp_valid  <= 1'b0;
            rsp_last   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (load) begin
                        state      <= SQ_CMD;
                        ph         <= 1'b0;
                        cnt        <= cmd_last_bit(sel_setup);
                        bytes_left <= req_len;
                        mode_q     <= sel_setup.lanes;
                        cs_n       <= ~(NUM_CS'(1) << req_cs);
                    end
                end
                SQ_CMD: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (cnt == 7'd0) begin
                            state <= SQ_DATA;
                            cnt   <= {4'd0, last_chunk(mode_q)};
                        end else begin
                            cnt <= cnt - 7'd1;
                        end
                    end
                end
                SQ_DATA: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (cnt == 7'd0) begin
                            rsp_valid <= 1'b1;
                            if (bytes_left == LEN_W'(1)) begin
                                rsp_last <= 1'b1;
                                state    <= SQ_GAP;
                                cs_n     <= '1;
                            end else begin
                                bytes_left <= bytes_left - LEN_W'(1);
                                cnt        <= {4'd0, last_chunk(mode_q)};
                            end
                        end else begin
                            cnt <= cnt - 7'd1;
                        end
                    end
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/mmf_rd_top.sv
`timescale 1ns/1ps
module mmf_rd_top
    import mmf_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int CS_W      = $clog2(NUM_CS),
    parameter int CFG_IDX_W = $clog2(NUM_CS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [31:0]          cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CS_W-1:0]      req_cs,
    input  logic [LEN_W-1:0]     req_len,
    output logic                 rsp_valid,
    output logic [7:0]           rsp_data,
    output logic                 rsp_last,
    output logic                 fl_sclk,
    output logic [NUM_CS-1:0]    fl_cs_n,
    output logic [3:0]           fl_io_o,
    output logic [3:0]           fl_io_oe,
    input  logic [3:0]           fl_io_i
);

    logic                mm_on;
    setup_t [NUM_CS-1:0] setup_bank;
    setup_t              sel_setup;
    logic                load;
    logic                shift_en;
    logic                sample_en;
    logic [1:0]          mode;
    logic                tx_en;
    logic                tx_bit;

    assign sel_setup = setup_bank[req_cs];

    mmf_cfg_regs #(
        .NUM_CS    (NUM_CS),
        .CFG_IDX_W (CFG_IDX_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .mm_on      (mm_on),
        .setup_bank (setup_bank)
    );

    mmf_seq #(
        .NUM_CS (NUM_CS),
        .CS_W   (CS_W),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mm_on     (mm_on),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cs    (req_cs),
        .req_len   (req_len),
        .sel_setup (sel_setup),
        .load      (load),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .mode      (mode),
        .tx_en     (tx_en),
        .sclk      (fl_sclk),
        .cs_n      (fl_cs_n),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last)
    );

    mmf_shifter #(
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .sel_setup (sel_setup),
        .addr      (req_addr),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .mode      (mode),
        .io_in     (fl_io_i),
        .tx_bit    (tx_bit),
        .rx_byte   (rsp_data)
    );

    assign fl_io_o  = {3'b000, tx_bit};
    assign fl_io_oe = {3'b000, tx_en};

endmodule

// File: rtl/mmf_checker.sv
`timescale 1ns/1ps
module mmf_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mm_on,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_last,
    input logic              fl_sclk,
    input logic [NUM_CS-1:0] fl_cs_n,
    input logic [3:0]        fl_io_o,
    input logic [3:0]        fl_io_oe
);

    // R1
    held_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (&fl_cs_n && !mm_on) |=> &fl_cs_n);

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~fl_cs_n) <= 1);

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        &fl_cs_n |-> !fl_sclk);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && !(&fl_cs_n)));

    // R10
    last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    // R10
    mid_byte_select_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_last) |-> !(&fl_cs_n));

    // R12
    launch_low_chk: assert property (@(posedge clk) disable iff (rst)
        fl_sclk |-> $stable(fl_io_o));

    // R12
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        fl_sclk |=> !fl_sclk);

    // R5
    data_released_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (fl_io_oe == 4'b0000));

endmodule

bind mmf_rd_top mmf_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mm_on     (mm_on),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .fl_sclk   (fl_sclk),
    .fl_cs_n   (fl_cs_n),
    .fl_io_o   (fl_io_o),
    .fl_io_oe  (fl_io_oe)
);

// File: tb/tb_mmf_rd_top.sv
`timescale 1ns/1ps
module tb_mmf_rd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_cs = '0;
    logic [7:0]  req_len = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_last;
    logic        fl_sclk;
    logic [3:0]  fl_cs_n;
    logic [3:0]  fl_io_o;
    logic [3:0]  fl_io_oe;
    logic [3:0]  flash_drv = '0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    mmf_rd_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cs(req_cs), .req_len(req_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_o(fl_io_o),
        .fl_io_oe(fl_io_oe), .fl_io_i(flash_drv)
    );

    logic cs_idle;
    assign cs_idle = &fl_cs_n;

    // Bench copy of the setup words
    logic [7:0] op_b [4];
    int         am1_b [4];
    int         dn_b  [4];
    int         md_b  [4];

    // Scoreboard queues
    logic [7:0]  exp_d [$];
    logic        exp_l [$];
    string       exp_t [$];
    logic [7:0]  hdr_op [$];
    logic [31:0] hdr_a  [$];
    int          hdr_cs [$];

    function automatic logic [7:0] fdat(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] amask(input int am1);
        return (am1 == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (am1 + 1))) - 32'h1);
    endfunction

    function automatic string mode_tag(input int md);
        case (md)
            1:       return "R6";
            3:       return "R7";
            2:       return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cs(input int cs, input logic [7:0] op, input int am1,
                          input int dn, input int md);
        op_b[cs] = op; am1_b[cs] = am1; dn_b[cs] = dn; md_b[cs] = md;
        cfg_write(cs, {18'd0, 2'(md), 2'(dn), 2'(am1), op});
    endtask

    // Driver: push expectations, then hand the request over
    task automatic do_read(input int cs, input logic [31:0] addr, input int len);
        logic [31:0] m;
        m = amask(am1_b[cs]);
        hdr_op.push_back(op_b[cs]);
        hdr_a.push_back(addr & m);
        hdr_cs.push_back(cs);
        for (int k = 0; k < len; k++) begin
            exp_d.push_back(fdat((addr + 32'(k)) & m));
            exp_l.push_back(k == len - 1);
            exp_t.push_back(mode_tag(md_b[cs]));
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_cs = 2'(cs); req_len = 8'(len);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R11: busy right after acceptance
        chk("R11", "ready after accept", {63'd0, req_ready}, 64'd0);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while ((exp_d.size() != 0 || !cs_idle) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic hold_check(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R1", "ready while off", {63'd0, req_ready}, 64'd0);
        end
        chk("R1", "select while off", {60'd0, fl_cs_n}, 64'hF);
    endtask

    // Monitor: pop and compare bytes, watch the serial clock
    logic prev_act = 1'b0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_d.size() == 0) begin
                    chk("R10", "unexpected byte", {56'd0, rsp_data}, 64'hFFFF);
                end else begin
                    chk(exp_t[0], "data byte", {56'd0, rsp_data}, {56'd0, exp_d[0]});
                    chk("R10", "last flag", {63'd0, rsp_last}, {63'd0, exp_l[0]});
                    void'(exp_d.pop_front());
                    void'(exp_l.pop_front());
                    void'(exp_t.pop_front());
                end
            end
            if (!cs_idle && prev_act)
                chk("R12", "sclk toggles", {63'd0, fl_sclk}, {63'd0, ~prev_sclk});
            if (cs_idle && fl_sclk)
                chk("R9", "sclk idle low", {63'd0, fl_sclk}, 64'd0);
        end
        prev_act  <= !cs_idle;
        prev_sclk <= fl_sclk;
    end

    // Flash model
    initial begin
        forever begin
            int          sel;
            int          am, dn, md, nbits, w, left;
            logic [63:0] cmd;
            logic [31:0] a, m;
            logic [7:0]  cur;
            @(negedge cs_idle);
            sel = 0;
            for (int j = 0; j < 4; j++) if (!fl_cs_n[j]) sel = j;
            am = am1_b[sel]; dn = dn_b[sel]; md = md_b[sel];
            m = amask(am);
            nbits = 8 * (2 + am + dn);
            cmd = '0;
            for (int i = 0; i < nbits; i++) begin
                @(posedge fl_sclk);
                cmd = {cmd[62:0], fl_io_o[0]};
            end
            a = 32'(cmd >> (8 * dn)) & m;
            if (hdr_op.size() == 0) begin
                chk("R2", "unexpected sequence", 64'd0, 64'd1);
            end else begin
                chk("R2", "opcode", {56'd0, cmd[nbits-1 -: 8]}, {56'd0, hdr_op[0]});
                chk("R3", "address", {32'd0, a}, {32'd0, hdr_a[0]});
                chk("R9", "chip select", 64'(sel), 64'(hdr_cs[0]));
                void'(hdr_op.pop_front());
                void'(hdr_a.pop_front());
                void'(hdr_cs.pop_front());
            end
            if (dn != 0)
                chk("R4", "dummy bits", cmd & ((64'd1 << (8 * dn)) - 64'd1), 64'd0);
            w = (md == 3) ? 4 : ((md == 1) ? 2 : 1);
            cur = fdat(a);
            left = 8;
            while (1) begin
                @(negedge fl_sclk or posedge cs_idle);
                #1;
                if (cs_idle) break;
                if (left == 0) begin
                    a = (a + 32'd1) & m;
                    cur = fdat(a);
                    left = 8;
                end
                case (w)
                    4: flash_drv = cur[7:4];
                    2: flash_drv = {2'b00, cur[7:6]};
                    default: flash_drv = {2'b00, cur[7], 1'b0};
                endcase
                cur = cur << w;
                left = left - w;
            end
            flash_drv = '0;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 and R9 reset state
        chk("R1", "ready in reset", {63'd0, req_ready}, 64'd0);
        chk("R9", "selects in reset", {60'd0, fl_cs_n}, 64'hF);
        chk("R9", "sclk in reset", {63'd0, fl_sclk}, 64'd0);
        chk("R10", "valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst = 1'b0;

        set_cs(0, 8'h03, 2, 0, 0);
        set_cs(1, 8'h3B, 3, 1, 1);
        set_cs(2, 8'h6B, 2, 1, 3);
        set_cs(3, 8'h0B, 1, 2, 2);

        // R1: held while switch off, accepted once it is set
        fork
            do_read(0, 32'h0000_1000, 4);
            begin
                hold_check(30);
                cfg_write(4, 32'h1);
            end
        join
        wait_idle();

        do_read(1, 32'h00AB_CDEF, 5);
        wait_idle();
        do_read(2, 32'h0002_0030, 16);
        wait_idle();
        // R3 truncation to two bytes, R8 reserved mode
        do_read(3, 32'h1234_5678, 3);
        wait_idle();
        do_read(0, 32'h0000_00FF, 1);
        wait_idle();

        // Back to back requests
        do_read(2, 32'h0000_7F00, 2);
        do_read(1, 32'h0102_0304, 3);
        wait_idle();

        // R2: a rewritten setup word takes effect on the next read
        set_cs(0, 8'hEB, 0, 3, 3);
        do_read(0, 32'h0000_01F0, 6);
        wait_idle();

        // R1: switch cleared again
        cfg_write(4, 32'h0);
        fork
            do_read(1, 32'h0000_0040, 2);
            begin
                hold_check(20);
                cfg_write(4, 32'h1);
            end
        join
        wait_idle();

        chk("R10", "bytes outstanding", 64'(exp_d.size()), 64'd0);
        chk("R2", "sequences outstanding", 64'(hdr_op.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule